// File: doc/BRIEF.md
# Event Latch Status Dual View

This block keeps the status of an acquisition FIFO. Three single-cycle event pulses each set a sticky latch: end-of-scan, FIFO threshold and data lost. Software can read these latches through two views. The primary view returns the two FIFO flag levels and all three latches, and the read clears the latches. The auxiliary view returns the flags, the data-lost latch and one summary bit, and the read leaves every latch as it was. With the auxiliary view, software can poll for activity without losing an event it has not yet handled.

Both read results are registered. A read strobe that is high in a cycle loads the matching output register at the next clock edge. The register then holds that value until the next read of the same view. A primary read captures the latches before it clears them. If an event pulse arrives in the same cycle as a clearing read, the latch is set again so that the event is not lost.

Top module: `evt_status_dual`

## Requirements
- R1: After reset all three latches are clear and both `priData` and `auxData` read 0.
- R2: A one-cycle pulse on `eosPulse`, `fifoEvtPulse` or `lostPulse` sets its latch, and the latch stays set with no further pulse until a primary read clears it.
- R3: The clock edge that ends a cycle with `priRead` high loads `priData` with: bits 1:0 = `fifoFlag`, bit 2 = data-lost latch, bit 3 = end-of-scan latch, bit 4 = FIFO-event latch, all other bits 0. The latch values are those from before that read's clear.
- R4: A primary read clears all three latches, so the next primary read shows bits 4:2 as 0 when no pulse arrived in between.
- R5: The clock edge that ends a cycle with `auxRead` high loads `auxData` with: bits 1:0 = `fifoFlag`, bit 2 = data-lost latch, bit 3 = OR of the end-of-scan and FIFO-event latches, all other bits 0.
- R6: An auxiliary read clears no latch. Repeated auxiliary reads and a later primary read still show the latched events.
- R7: An event pulse in the same cycle as a primary read leaves its latch set after the clear, and that read returns the latch value from before the pulse.
- R8: `priData` and `auxData` keep their value in cycles with no read of their own view, even when the flags or latches change.
- R9: A primary read and an auxiliary read in the same cycle both return the state from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoFlag | input | 2 | FIFO flag levels |
| eosPulse | input | 1 | End-of-scan event pulse |
| fifoEvtPulse | input | 1 | FIFO threshold event pulse |
| lostPulse | input | 1 | Data-lost event pulse |
| priRead | input | 1 | Primary (clearing) status read strobe |
| auxRead | input | 1 | Auxiliary (non-clearing) status read strobe |
| priData | output | 8 | Registered primary status image |
| auxData | output | 8 | Registered auxiliary status image |

## Verification
Two functions can fall in the same cycle: the clear caused by a primary read, and the set caused by an event pulse. The bench provokes this by raising `eosPulse` in the same cycle as `priRead`. It requires that this read shows the latch as it was before the pulse, and that the next primary read shows the latch set. A primary read and an auxiliary read in the same cycle are also driven together. The auxiliary result is judged against the pre-clear model state.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
  localparam int NUM_EVT  = 3;
  localparam int EVT_LOST = 0;
  localparam int EVT_EOS  = 1;
  localparam int EVT_FIFO = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic capPri;
    logic capAux;
    logic clrLatch;
  } ctlStrobe_t;
endpackage

// File: rtl/evt_status_ctrl.sv
module evt_status_ctrl
  import evt_status_pkg::*;
(
  input  logic       priRead,
  input  logic       auxRead,
  output ctlStrobe_t strb
);
  always_comb begin
    strb          = '0;
    strb.capPri   = priRead;
    strb.capAux   = auxRead;
    strb.clrLatch = priRead;   // only the primary view is destructive
  end
endmodule

// File: rtl/evt_status_dp.sv
module evt_status_dp
  import evt_status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strb,
  input  logic [FLAG_W-1:0]    fifoFlag,
  input  logic [NUM_EVT-1:0]   evtPulse,
  output logic [DATA_W-1:0]    priData,
  output logic [DATA_W-1:0]    auxData
);
  localparam int LOST_POS = FLAG_W;
  localparam int EOS_POS  = FLAG_W + 1;
  localparam int FIFO_POS = FLAG_W + 2;
  localparam int SUM_POS  = FLAG_W + 1;

  logic [NUM_EVT-1:0] latchQ;

  // one sticky latch per event; a new pulse wins over the clear
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_latch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            latchQ[i] <= 1'b0;
      else if (evtPulse[i]) latchQ[i] <= 1'b1;
      else if (strb.clrLatch) latchQ[i] <= 1'b0;
    end
  end

  logic [DATA_W-1:0] priImg, auxImg;

  always_comb begin
    priImg               = '0;
    priImg[FLAG_W-1:0]   = fifoFlag;
    priImg[LOST_POS]     = latchQ[EVT_LOST];
    priImg[EOS_POS]      = latchQ[EVT_EOS];
    priImg[FIFO_POS]     = latchQ[EVT_FIFO];
  end

  always_comb begin
    auxImg               = '0;
    auxImg[FLAG_W-1:0]   = fifoFlag;
    auxImg[LOST_POS]     = latchQ[EVT_LOST];
    auxImg[SUM_POS]      = latchQ[EVT_EOS] | latchQ[EVT_FIFO];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      priData <= '0;
      auxData <= '0;
    end else begin
      if (strb.capPri) priData <= priImg;
      if (strb.capAux) auxData <= auxImg;
    end
  end
endmodule

// File: rtl/evt_status_dual.sv
module evt_status_dual
  import evt_status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_W-1:0] fifoFlag,
  input  logic              eosPulse,
  input  logic              fifoEvtPulse,
  input  logic              lostPulse,
  input  logic              priRead,
  input  logic              auxRead,
  output logic [DATA_W-1:0] priData,
  output logic [DATA_W-1:0] auxData
);
  ctlStrobe_t         strb;
  logic [NUM_EVT-1:0] evtPulse;

  always_comb begin
    evtPulse           = '0;
    evtPulse[EVT_LOST] = lostPulse;
    evtPulse[EVT_EOS]  = eosPulse;
    evtPulse[EVT_FIFO] = fifoEvtPulse;
  end

  evt_status_ctrl u_ctrl (
    .priRead (priRead),
    .auxRead (auxRead),
    .strb    (strb)
  );

  evt_status_dp #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .fifoFlag (fifoFlag),
    .evtPulse (evtPulse),
    .priData  (priData),
    .auxData  (auxData)
  );
endmodule

// File: rtl/evt_status_chk.sv
module evt_status_chk #(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [FLAG_W-1:0] fifoFlag,
  input logic              eosPulse,
  input logic              fifoEvtPulse,
  input logic              lostPulse,
  input logic              priRead,
  input logic              auxRead,
  input logic [DATA_W-1:0] priData,
  input logic [DATA_W-1:0] auxData
);
  logic noPulse;
  assign noPulse = !eosPulse && !fifoEvtPulse && !lostPulse;

  AST_PRI_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    priRead |=> priData[FLAG_W-1:0] == $past(fifoFlag)); // R3
  AST_PRI_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    priData[DATA_W-1:FLAG_W+3] == '0); // R3
  AST_PRI_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (priRead && noPulse) ##1 (priRead && noPulse) |=> priData[FLAG_W+2:FLAG_W] == '0); // R4
  AST_AUX_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    auxRead |=> auxData[FLAG_W-1:0] == $past(fifoFlag)); // R5
  AST_AUX_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    auxData[DATA_W-1:FLAG_W+2] == '0); // R5
  AST_AUX_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (auxRead && !priRead) ##1 (auxRead && !priRead) |=>
      (!$past(auxData[FLAG_W+1]) || auxData[FLAG_W+1])); // R6
  AST_PULSE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (priRead && eosPulse) ##1 priRead |=> priData[FLAG_W+1]); // R7
  AST_PRI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !priRead |=> $stable(priData)); // R8
  AST_AUX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !auxRead |=> $stable(auxData)); // R8
endmodule

bind evt_status_dual evt_status_chk #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_chk (
  .clk(clk), .rstN(rstN), .fifoFlag(fifoFlag), .eosPulse(eosPulse),
  .fifoEvtPulse(fifoEvtPulse), .lostPulse(lostPulse), .priRead(priRead),
  .auxRead(auxRead), .priData(priData), .auxData(auxData)
);

// File: tb/evt_status_dual_test.sv
`timescale 1ns/1ps
module evt_status_dual_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] fifoFlag = '0;
  logic       eosPulse = 1'b0, fifoEvtPulse = 1'b0, lostPulse = 1'b0;
  logic       priRead = 1'b0, auxRead = 1'b0;
  logic [7:0] priData, auxData;

  int testsRun = 0;
  int testsFail = 0;
  bit finished = 0;
  bit monOn = 0;

  // expected results, one entry per clock edge
  logic [7:0] expPriQ[$];
  logic [7:0] expAuxQ[$];
  string      reqQ[$];

  // bench model
  logic mLost = 0, mEos = 0, mFifo = 0;
  logic [7:0] mPri = '0, mAux = '0;

  always #10 clk = ~clk;

  evt_status_dual uut (
    .clk(clk), .rstN(rstN), .fifoFlag(fifoFlag), .eosPulse(eosPulse),
    .fifoEvtPulse(fifoEvtPulse), .lostPulse(lostPulse), .priRead(priRead),
    .auxRead(auxRead), .priData(priData), .auxData(auxData)
  );

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus at the falling edge, push expectation
  task automatic step(input logic [1:0] fl, input logic eos, input logic fe,
                      input logic lost, input logic pr, input logic ar, input string req);
    @(negedge clk);
    fifoFlag = fl; eosPulse = eos; fifoEvtPulse = fe; lostPulse = lost;
    priRead = pr; auxRead = ar;
    if (pr) mPri = {3'b000, mFifo, mEos, mLost, fl};
    if (ar) mAux = {4'b0000, mEos | mFifo, mLost, fl};
    if (pr) begin mLost = 0; mEos = 0; mFifo = 0; end
    if (lost) mLost = 1;
    if (eos)  mEos  = 1;
    if (fe)   mFifo = 1;
    expPriQ.push_back(mPri);
    expAuxQ.push_back(mAux);
    reqQ.push_back(req);
  endtask

  // monitor: compare a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    if (monOn && reqQ.size() > 0) begin
      string r;
      logic [7:0] ep, ea;
      r = reqQ.pop_front();
      ep = expPriQ.pop_front();
      ea = expAuxQ.pop_front();
      check(r, "priData", priData, ep);
      check(r, "auxData", auxData, ea);
    end
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      testsFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "priData reset", priData, 8'h00);
    check("R1", "auxData reset", auxData, 8'h00);
    rstN = 1'b1;
    monOn = 1;
    // R1: latches start clear
    step(2'b01, 0, 0, 0, 0, 1, "R1");
    step(2'b01, 0, 0, 0, 1, 0, "R1");
    // R2, R5: end-of-scan latched, summary bit via aux
    step(2'b00, 1, 0, 0, 0, 0, "R2");
    step(2'b10, 0, 0, 0, 0, 0, "R8");
    step(2'b11, 0, 0, 0, 0, 1, "R5");
    // R6: aux read repeats do not clear
    step(2'b11, 0, 0, 0, 0, 1, "R6");
    step(2'b11, 0, 0, 0, 0, 1, "R6");
    // R3 then R4
    step(2'b01, 0, 0, 0, 1, 0, "R3");
    step(2'b01, 0, 0, 0, 1, 0, "R4");
    step(2'b00, 0, 0, 0, 0, 1, "R4");
    // R2/R5: FIFO event and data lost, summary via FIFO latch
    step(2'b10, 0, 1, 0, 0, 0, "R2");
    step(2'b10, 0, 0, 1, 0, 0, "R2");
    step(2'b10, 0, 0, 0, 0, 0, "R8");
    step(2'b10, 0, 0, 0, 0, 1, "R5");
    step(2'b01, 0, 0, 0, 1, 0, "R3");
    step(2'b01, 0, 0, 0, 0, 1, "R4");
    // R7: pulse coincides with clearing read
    step(2'b00, 1, 0, 0, 0, 0, "R7");
    step(2'b00, 1, 0, 0, 1, 0, "R7");
    step(2'b00, 0, 0, 0, 1, 0, "R7");
    step(2'b00, 0, 1, 1, 1, 0, "R7");
    step(2'b11, 0, 0, 0, 0, 1, "R7");
    // R9: both views in one cycle
    step(2'b10, 0, 0, 0, 0, 0, "R9");
    step(2'b10, 1, 0, 0, 0, 0, "R9");
    step(2'b10, 0, 0, 0, 1, 1, "R9");
    step(2'b10, 0, 0, 0, 0, 1, "R9");
    // R8: inputs move with no reads
    step(2'b01, 1, 1, 1, 0, 0, "R8");
    step(2'b10, 0, 0, 0, 0, 0, "R8");
    step(2'b11, 0, 0, 0, 1, 0, "R3");
    step(2'b11, 0, 0, 0, 1, 1, "R4");
    step(2'b00, 0, 0, 0, 0, 0, "R8");
    step(2'b00, 0, 0, 0, 0, 0, "R8");
    repeat (3) @(posedge clk);
    #6;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end
endmodule